// File: doc/BRIEF.md
# Five-Step Instruction Sequencer

This block is the control unit of a small accumulator processor. A step counter walks through five clock steps for every instruction. From the current step and the 4-bit opcode held in the instruction register, the block drives the fourteen control strobes of the datapath. These strobes name which unit places a byte on the shared bus, which units capture it, whether the program counter advances, and whether the ALU subtracts.

The first two steps fetch the instruction and are the same for every opcode, because the instruction register has not been loaded while they run. The program counter advances in the second fetch step, on the same edge that captures the instruction. Every instruction gets the full five steps, which is the length the add instruction needs. Shorter instructions leave their unused steps empty.

A halt opcode stops the sequencer until reset. An external run input acts as a clock enable: while it is low the sequencer holds its step.

Top module: `insn_sequencer`

## Requirements
- R1: Reset puts the step counter at step 0. The counter then advances once per enabled clock through steps 0, 1, 2, 3 and 4, and returns to step 0 after step 4.
- R2: In step 0, only pc_drive and addr_load are high, whatever the opcode.
- R3: In step 1, only mem_drive, ir_load and pc_step are high, whatever the opcode.
- R4: ADD (opcode 0x2) drives the following strobes. Step 2: ir_drive and addr_load. Step 3: mem_drive and opb_load. Step 4: alu_drive and acc_load. SUB (opcode 0x3) is the same, except that alu_sub is also high in step 4.
- R5: The remaining opcodes drive the following strobes, and all their other execute steps are empty.
  - STA (0x4): ir_drive and addr_load in step 2, then acc_drive and mem_write in step 3.
  - LDI (0x5): ir_drive and acc_load in step 2.
  - JMP (0x6): ir_drive and pc_load in step 2.
  - OUT (0xE): acc_drive and disp_load in step 2.
- R6: Any other opcode except HALT drives no strobe in steps 2 to 4.
- R7: At most one of pc_drive, mem_drive, ir_drive, acc_drive and alu_drive is high at any time.
- R8: HALT (0xF) drives no strobe in step 2. On the enabled edge that leaves step 2, halted rises. From then on all strobes stay low and the step does not change until reset, which clears halted.
- R9: While run_en is low, the step does not advance and the strobes keep their values. A HALT in step 2 takes no effect until run_en is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Clock enable for the step counter |
| opcode | input | 4 | Upper nibble of the instruction register |
| pc_drive | output | 1 | Program counter drives the bus |
| mem_drive | output | 1 | Memory drives the bus |
| ir_drive | output | 1 | Instruction operand drives the bus |
| acc_drive | output | 1 | Accumulator drives the bus |
| alu_drive | output | 1 | ALU result drives the bus |
| addr_load | output | 1 | Address register loads from the bus |
| mem_write | output | 1 | Memory writes the bus value |
| ir_load | output | 1 | Instruction register loads |
| acc_load | output | 1 | Accumulator loads |
| opb_load | output | 1 | ALU second-operand register loads |
| disp_load | output | 1 | Display register loads |
| pc_load | output | 1 | Program counter loads (jump) |
| pc_step | output | 1 | Program counter increments |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| halted | output | 1 | Sequencer has stopped |

## Verification
Two functions fall in the same cycle. In step 1 the instruction capture and the program-counter increment are raised together. In step 2 a HALT opcode meets a run_en that may be low. The bench drives a different opcode during both fetch steps, so an opcode-dependent fetch word shows up as a mismatch. It also parks run_en low in step 2 with HALT present, and requires that halted stays low until the first enabled edge and then rises on exactly that edge.

// File: rtl/insn_sequencer.sv
module insn_sequencer #(
  parameter int STEPS = 5,
  parameter int OP_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_drive,
  output logic            mem_drive,
  output logic            ir_drive,
  output logic            acc_drive,
  output logic            alu_drive,
  output logic            addr_load,
  output logic            mem_write,
  output logic            ir_load,
  output logic            acc_load,
  output logic            opb_load,
  output logic            disp_load,
  output logic            pc_load,
  output logic            pc_step,
  output logic            alu_sub,
  output logic            halted
);
  localparam int SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);
  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SUB  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_STA  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_LDI  = OP_W'(5);
  localparam logic [OP_W-1:0] OP_JMP  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_OUT  = OP_W'(14);
  localparam logic [OP_W-1:0] OP_HALT = OP_W'(15);

  logic [SW-1:0] step;
  logic          running;
  logic          adv;

  assign adv    = run_en && running;
  assign halted = !running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      running <= 1'b1;
    end else if (adv) begin
      if (step == SW'(2) && opcode == OP_HALT)
        running <= 1'b0;
      else if (step == LAST)
        step <= '0;
      else
        step <= step + 1'b1;
    end
  end

  always_comb begin
    {pc_drive, mem_drive, ir_drive, acc_drive, alu_drive} = '0;
    {addr_load, mem_write, ir_load, acc_load, opb_load, disp_load, pc_load} = '0;
    {pc_step, alu_sub} = '0;
    if (running) begin
      case (step)
        SW'(0): begin
          pc_drive  = 1'b1;
          addr_load = 1'b1;
        end
        SW'(1): begin
          mem_drive = 1'b1;
          ir_load   = 1'b1;
          pc_step   = 1'b1;
        end
        SW'(2): begin
          case (opcode)
            OP_ADD, OP_SUB, OP_STA: begin ir_drive = 1'b1; addr_load = 1'b1; end
            OP_LDI: begin ir_drive = 1'b1; acc_load = 1'b1; end
            OP_JMP: begin ir_drive = 1'b1; pc_load = 1'b1; end
            OP_OUT: begin acc_drive = 1'b1; disp_load = 1'b1; end
            default: ;
          endcase
        end
        SW'(3): begin
          case (opcode)
            OP_ADD, OP_SUB: begin mem_drive = 1'b1; opb_load = 1'b1; end
            OP_STA: begin acc_drive = 1'b1; mem_write = 1'b1; end
            default: ;
          endcase
        end
        SW'(4): begin
          if (opcode == OP_ADD || opcode == OP_SUB) begin
            alu_drive = 1'b1;
            acc_load  = 1'b1;
            alu_sub   = (opcode == OP_SUB);
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step == LAST) |=> step == '0);
  a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_drive, mem_drive, ir_drive, acc_drive, alu_drive}));
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(step));
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(pc_step || pc_load || ir_load || acc_load || mem_write));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(step) && $stable(halted));
endmodule

// File: tb/test_insn_sequencer.sv
module test_insn_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b1;
  logic [3:0] opcode = 4'h0;
  logic pc_drive, mem_drive, ir_drive, acc_drive, alu_drive;
  logic addr_load, mem_write, ir_load, acc_load, opb_load, disp_load, pc_load;
  logic pc_step, alu_sub, halted;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  insn_sequencer i_insn_sequencer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .opcode(opcode),
    .pc_drive(pc_drive), .mem_drive(mem_drive), .ir_drive(ir_drive),
    .acc_drive(acc_drive), .alu_drive(alu_drive), .addr_load(addr_load),
    .mem_write(mem_write), .ir_load(ir_load), .acc_load(acc_load),
    .opb_load(opb_load), .disp_load(disp_load), .pc_load(pc_load),
    .pc_step(pc_step), .alu_sub(alu_sub), .halted(halted));

  localparam logic [13:0] PD = 14'h2000, MD = 14'h1000, ID = 14'h0800,
    AD = 14'h0400, LD = 14'h0200, MA = 14'h0100, MW = 14'h0080,
    IL = 14'h0040, AL = 14'h0020, BL = 14'h0010, DL = 14'h0008,
    PL = 14'h0004, PS = 14'h0002, SB = 14'h0001, Z = 14'h0000;
  localparam logic [13:0] F0 = PD | MA;
  localparam logic [13:0] F1 = MD | IL | PS;

  localparam logic [17:0] VEC [40] = '{
    {4'h2, F0}, {4'h2, F1}, {4'h2, ID|MA}, {4'h2, MD|BL}, {4'h2, LD|AL},
    {4'h3, F0}, {4'h3, F1}, {4'h3, ID|MA}, {4'h3, MD|BL}, {4'h3, LD|AL|SB},
    {4'h4, F0}, {4'h4, F1}, {4'h4, ID|MA}, {4'h4, AD|MW}, {4'h4, Z},
    {4'h5, F0}, {4'h5, F1}, {4'h5, ID|AL}, {4'h5, Z},     {4'h5, Z},
    {4'hE, F0}, {4'hE, F1}, {4'hE, AD|DL}, {4'hE, Z},     {4'hE, Z},
    {4'h6, F0}, {4'h6, F1}, {4'h6, ID|PL}, {4'h6, Z},     {4'h6, Z},
    {4'h9, F0}, {4'h9, F1}, {4'h9, Z},     {4'h9, Z},     {4'h9, Z},
    {4'h0, F0}, {4'h0, F1}, {4'h0, Z},     {4'h0, Z},     {4'h0, Z}
  };

  function automatic logic [13:0] word();
    return {pc_drive, mem_drive, ir_drive, acc_drive, alu_drive, addr_load,
            mem_write, ir_load, acc_load, opb_load, disp_load, pc_load,
            pc_step, alu_sub};
  endfunction

  task automatic check(input logic [14:0] got, input logic [14:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    opcode = 4'h2;
    do_reset();
    check({halted, word()}, {1'b0, F0}, "R1 reset state");

    for (int op = 0; op < 8; op++) begin
      logic [3:0] code;
      code = VEC[op*5][17:14];
      do_reset();
      opcode = ~code;
      for (int s = 0; s < 5; s++) begin
        string req;
        if (s == 2) begin opcode = code; #1; end
        if (s == 0) req = "R2 fetch step 0";
        else if (s == 1) req = "R3 fetch step 1";
        else if (code == 4'h2 || code == 4'h3) req = "R4 arith step";
        else if (code == 4'h9 || code == 4'h0) req = "R6 unknown opcode";
        else req = "R5 short op step";
        check({halted, word()}, {1'b0, VEC[op*5+s][13:0]}, req);
        check({14'b0, $countones(word() & 14'h3E00) > 1},
              15'b0, "R7 single bus driver");
        @(negedge clk); #1;
      end
      check({halted, word()}, {1'b0, F0}, "R1 wrap to step 0");
    end

    do_reset();
    @(negedge clk); #1;
    run_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check({halted, word()}, {1'b0, F1}, "R9 hold in step 1");
    end
    run_en = 1'b1;
    @(negedge clk); #1;
    opcode = 4'hF; #1;
    check({halted, word()}, {1'b0, Z}, "R8 halt step 2 empty");
    run_en = 1'b0;
    @(negedge clk); #1;
    check({14'b0, halted}, 15'b0, "R9 halt deferred while disabled");
    run_en = 1'b1;
    @(negedge clk); #1;
    check({halted, word()}, {1'b1, Z}, "R8 halted after edge");
    opcode = 4'h2;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check({halted, word()}, {1'b1, Z}, "R8 stays halted");
    end
    do_reset();
    check({halted, word()}, {1'b0, F0}, "R8 reset clears halt");
    @(negedge clk); #1;
    check({halted, word()}, {1'b0, F1}, "R1 resumes stepping");
    finish_run();
  end
endmodule